// File: doc/BRIEF.md
# Triple-Path Receiver Response Voter

This block sits behind three redundant comparators on a two-wire current-mode bus. The comparators watch the high line, the low line and the sum of the two. Each one produces a serial bit stream. A slave-sync strobe marks the bit slots. On each falling edge of the strobe, the block shifts one bit from every stream into its own register. The sum stream goes into two separate registers, one for each output channel.

At the end of a frame, the block checks a 4-bit CRC on every captured frame. It also compares the high and low patterns bit by bit. From these results it picks one valid path for each of the two output channels, if there is one:

- Channel 0 chooses between the high path and its own sum copy.
- Channel 1 chooses between the low path and its own sum copy.

The two decisions use separate logic, so a single fault cannot disturb both channels. Each channel presents a data word, an error bit and a one-cycle done strobe.

Frames are `DATA_W` data bits followed by 4 CRC bits. Bits arrive most significant first, so the data word is the first `DATA_W` bits received. The CRC uses the polynomial x^4+x+1, starts from the parameter `CRC_SEED`, and runs over the data bits only.

Top module: `rx_vote`

## Requirements
- R1: A bit is captured from each stream only on a falling edge of `sync_in`, seen through a two-stage synchronizer. Values present while the strobe is high, or after the capture, have no effect.
- R2: A pulse on `frame_start` empties every capture register. Bits shifted in before it do not appear in the next result.
- R3: A channel outputs its own-side data with error 0 under two conditions. The own-side frame (high for channel 0, low for channel 1) must pass its CRC. The high and low frames must also be identical.
- R4: The sum data is output with error 0 in one case. The own-side path must fail its CRC, or the high and low frames must differ. The sum frame must also pass its CRC.
- R5: When neither path is valid, the channel sets its error bit and outputs the sum data word.
- R6: If the high or low frame is all ones, CRC bits included, both channels set their error bits. This holds whatever the sum frame holds.
- R7: One clock after `frame_end`, both `ch0_done` and `ch1_done` are high for exactly one cycle, and the new results appear at the same time.
- R8: While `rst_n` is low at a clock edge, all data outputs, error bits and done strobes are cleared.
- R9: Data and error outputs hold their values between `frame_end` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Slave-sync strobe; falling edge samples the streams |
| rx_hi | input | 1 | High-side receiver bit |
| rx_lo | input | 1 | Low-side receiver bit |
| rx_sum | input | 1 | Summed receiver bit |
| frame_start | input | 1 | Clears the capture registers |
| frame_end | input | 1 | Latches the decision |
| ch0_data | output | DATA_W | Channel 0 selected data word |
| ch0_err | output | 1 | Channel 0 error flag |
| ch0_done | output | 1 | Channel 0 result strobe |
| ch1_data | output | DATA_W | Channel 1 selected data word |
| ch1_err | output | 1 | Channel 1 error flag |
| ch1_done | output | 1 | Channel 1 result strobe |

## Verification
The hardest condition to reach is a frame where the high and low paths both carry frames with correct CRCs that still differ. In that case only the XOR comparison can reject the own-side paths. The bench drives two distinct valid frames on the high and low streams and a third valid frame on the sum stream, and expects both channels to return the third word.

A second hard condition is the all-ones override. Here both lines carry twelve ones while the sum path is clean, so the error must come from the override and not from a CRC failure.

Sampling discipline is exercised by a variant of the bit task. It holds wrong levels while the strobe is high and restores wrong levels once the capture window has passed.

// File: rtl/rx_vote.sv
module rx_vote #(
  parameter int DATA_W = 8,
  parameter logic [3:0] CRC_SEED = 4'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_in,
  input  logic              rx_hi,
  input  logic              rx_lo,
  input  logic              rx_sum,
  input  logic              frame_start,
  input  logic              frame_end,
  output logic [DATA_W-1:0] ch0_data,
  output logic              ch0_err,
  output logic              ch0_done,
  output logic [DATA_W-1:0] ch1_data,
  output logic              ch1_err,
  output logic              ch1_done
);
  localparam int FRAME_W = DATA_W + 4;

  function automatic logic crc_ok(input logic [FRAME_W-1:0] f);
    logic [3:0] c;
    logic fb;
    c = CRC_SEED;
    for (int i = FRAME_W - 1; i >= 4; i--) begin
      fb = c[3] ^ f[i];
      c = {c[2:0], 1'b0} ^ {2'b00, fb, fb};
    end
    return c == f[3:0];
  endfunction

  logic [2:0] sy;
  logic       smp;
  logic [FRAME_W-1:0] sh_hi, sh_lo, sh_s0, sh_s1;

  always_ff @(posedge clk) begin
    if (!rst_n) sy <= '0;
    else        sy <= {sy[1:0], sync_in};
  end
  assign smp = sy[2] & ~sy[1];

  always_ff @(posedge clk) begin
    if (!rst_n || frame_start) begin
      sh_hi <= '0;
      sh_lo <= '0;
      sh_s0 <= '0;
      sh_s1 <= '0;
    end else if (smp) begin
      sh_hi <= {sh_hi[FRAME_W-2:0], rx_hi};
      sh_lo <= {sh_lo[FRAME_W-2:0], rx_lo};
      sh_s0 <= {sh_s0[FRAME_W-2:0], rx_sum};
      sh_s1 <= {sh_s1[FRAME_W-2:0], rx_sum};
    end
  end

  logic ok_hi, ok_lo, ok_s0, ok_s1, diff, ones;
  assign ok_hi = crc_ok(sh_hi);
  assign ok_lo = crc_ok(sh_lo);
  assign ok_s0 = crc_ok(sh_s0);
  assign ok_s1 = crc_ok(sh_s1);
  assign diff  = |(sh_hi ^ sh_lo);
  assign ones  = (&sh_hi) | (&sh_lo);

  logic [DATA_W-1:0] nx0_data, nx1_data;
  logic nx0_err, nx1_err;

  always_comb begin
    nx0_err = 1'b0;
    if (ok_hi && !diff)  nx0_data = sh_hi[FRAME_W-1:4];
    else begin
      nx0_data = sh_s0[FRAME_W-1:4];
      nx0_err  = !ok_s0;
    end
    if (ones) nx0_err = 1'b1;
  end

  always_comb begin
    nx1_err = 1'b0;
    if (ok_lo && !diff)  nx1_data = sh_lo[FRAME_W-1:4];
    else begin
      nx1_data = sh_s1[FRAME_W-1:4];
      nx1_err  = !ok_s1;
    end
    if (ones) nx1_err = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch0_data <= '0; ch0_err <= 1'b0; ch0_done <= 1'b0;
      ch1_data <= '0; ch1_err <= 1'b0; ch1_done <= 1'b0;
    end else begin
      ch0_done <= frame_end;
      ch1_done <= frame_end;
      if (frame_end) begin
        ch0_data <= nx0_data; ch0_err <= nx0_err;
        ch1_data <= nx1_data; ch1_err <= nx1_err;
      end
    end
  end

  // R7
  done_follows_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch0_done || ch1_done) |-> $past(frame_end));

  // R6
  ones_force_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && ((&sh_hi) || (&sh_lo))) |=> (ch0_err && ch1_err));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> ($stable(ch0_data) && $stable(ch1_data) && $stable(ch0_err) && $stable(ch1_err)));

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (sh_hi == '0 && sh_lo == '0 && sh_s0 == '0));

  // R5
  none_valid_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !ok_s0 && !(ok_hi && !diff)) |=> ch0_err);

  // R4
  dup_sum_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_s0 == sh_s1);
endmodule

// File: tb/test_rx_vote.sv
module test_rx_vote;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int FW = DW + 4;

  logic clk = 0, rst_n = 0, sync_in = 0, rx_hi = 0, rx_lo = 0, rx_sum = 0;
  logic frame_start = 0, frame_end = 0;
  logic [DW-1:0] ch0_data, ch1_data;
  logic ch0_err, ch0_done, ch1_err, ch1_done;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_vote #(.DATA_W(DW), .CRC_SEED(4'h0)) i_rx_vote (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .rx_hi(rx_hi), .rx_lo(rx_lo),
    .rx_sum(rx_sum), .frame_start(frame_start), .frame_end(frame_end),
    .ch0_data(ch0_data), .ch0_err(ch0_err), .ch0_done(ch0_done),
    .ch1_data(ch1_data), .ch1_err(ch1_err), .ch1_done(ch1_done));

  function automatic logic [3:0] crc_of(input logic [DW-1:0] d);
    logic [4:0] r;
    r = 5'd0;
    for (int i = DW - 1; i >= 0; i--) begin
      r = {r[3:0], 1'b0};
      if (r[4] ^ d[i]) r = r ^ 5'b10011;
      r[4] = 1'b0;
    end
    return r[3:0];
  endfunction

  function automatic logic [FW-1:0] mk(input logic [DW-1:0] d);
    return {d, crc_of(d)};
  endfunction

  function automatic logic good(input logic [FW-1:0] f);
    return crc_of(f[FW-1:4]) == f[3:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic h, input logic l, input logic s, input bit noisy);
    rx_hi = noisy ? ~h : h; rx_lo = noisy ? ~l : l; rx_sum = noisy ? ~s : s;
    sync_in = 1;
    repeat (4) @(negedge clk);
    rx_hi = h; rx_lo = l; rx_sum = s;
    sync_in = 0;
    repeat (3) @(negedge clk);
    if (noisy) begin rx_hi = ~h; rx_lo = ~l; rx_sum = ~s; end
    repeat (2) @(negedge clk);
  endtask

  task automatic run_frame(input logic [FW-1:0] h, input logic [FW-1:0] l,
                           input logic [FW-1:0] s, input bit noisy, input bit do_start);
    if (do_start) begin
      frame_start = 1; @(negedge clk); frame_start = 0;
    end
    for (int i = FW - 1; i >= 0; i--) send_bit(h[i], l[i], s[i], noisy);
    frame_end = 1; @(negedge clk); frame_end = 0;
  endtask

  task automatic expect_out(input string req, input logic [FW-1:0] h, input logic [FW-1:0] l,
                            input logic [FW-1:0] s);
    logic [DW-1:0] d0, d1;
    logic e0, e1, same, ones;
    same = (h == l);
    ones = (&h) || (&l);
    if (good(h) && same) begin d0 = h[FW-1:4]; e0 = 0; end
    else begin d0 = s[FW-1:4]; e0 = !good(s); end
    if (good(l) && same) begin d1 = l[FW-1:4]; e1 = 0; end
    else begin d1 = s[FW-1:4]; e1 = !good(s); end
    if (ones) begin e0 = 1; e1 = 1; end
    chk({req, " ch0_data"}, 32'(ch0_data), 32'(d0));
    chk({req, " ch0_err"}, 32'(ch0_err), 32'(e0));
    chk({req, " ch1_data"}, 32'(ch1_data), 32'(d1));
    chk({req, " ch1_err"}, 32'(ch1_err), 32'(e1));
    chk("R7 done high", 32'({ch0_done, ch1_done}), 32'h3);
    @(negedge clk);
    chk("R7 done one cycle", 32'({ch0_done, ch1_done}), 32'h0);
  endtask

  task automatic t_reset();
    chk("R8 reset ch0_data", 32'(ch0_data), 0);
    chk("R8 reset ch1_data", 32'(ch1_data), 0);
    chk("R8 reset err", 32'({ch0_err, ch1_err}), 0);
    chk("R8 reset done", 32'({ch0_done, ch1_done}), 0);
  endtask

  task automatic t_own();
    logic [FW-1:0] a, s;
    a = mk(8'hA5); s = mk(8'h3C);
    run_frame(a, a, s, 0, 1);
    expect_out("R3 own path", a, a, s);
  endtask

  task automatic t_mismatch();
    logic [FW-1:0] h, l, s;
    h = mk(8'h12); l = mk(8'h34); s = mk(8'h56);
    run_frame(h, l, s, 0, 1);
    expect_out("R4 xor mismatch", h, l, s);
    chk("R4 ch0 sum word", 32'(ch0_data), 32'h56);
  endtask

  task automatic t_own_crc_bad();
    logic [FW-1:0] h, s;
    h = mk(8'h77) ^ 12'h001; s = mk(8'hC3);
    run_frame(h, h, s, 0, 1);
    expect_out("R4 own crc fail", h, h, s);
  endtask

  task automatic t_none();
    logic [FW-1:0] h, l, s;
    h = mk(8'h0F) ^ 12'h002; l = h; s = mk(8'hE1) ^ 12'h004;
    run_frame(h, l, s, 0, 1);
    expect_out("R5 no valid path", h, l, s);
    chk("R5 err both", 32'({ch0_err, ch1_err}), 32'h3);
  endtask

  task automatic t_ones();
    logic [FW-1:0] s;
    s = mk(8'h5A);
    run_frame('1, '1, s, 0, 1);
    expect_out("R6 all ones both", '1, '1, s);
    run_frame('1, mk(8'h5A), s, 0, 1);
    expect_out("R6 all ones high", '1, mk(8'h5A), s);
    chk("R6 err forced", 32'({ch0_err, ch1_err}), 32'h3);
  endtask

  task automatic t_start_clear();
    logic [FW-1:0] a, s;
    a = mk(8'h81); s = mk(8'h18);
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0, 1'b1, 0);
    run_frame(a, a, s, 0, 1);
    expect_out("R2 start clears", a, a, s);
  endtask

  task automatic t_noisy();
    logic [FW-1:0] a, s;
    a = mk(8'h96); s = mk(8'h69);
    run_frame(a, a, s, 1, 1);
    expect_out("R1 falling edge sampling", a, a, s);
  endtask

  task automatic t_hold();
    logic [DW-1:0] d0, d1;
    logic [1:0] e;
    d0 = ch0_data; d1 = ch1_data; e = {ch0_err, ch1_err};
    frame_start = 1; @(negedge clk); frame_start = 0;
    for (int i = 0; i < 6; i++) send_bit(i[0], ~i[0], 1'b1, 0);
    chk("R9 hold ch0_data", 32'(ch0_data), 32'(d0));
    chk("R9 hold ch1_data", 32'(ch1_data), 32'(d1));
    chk("R9 hold err", 32'({ch0_err, ch1_err}), 32'(e));
    chk("R7 no done without end", 32'({ch0_done, ch1_done}), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_own();
    t_mismatch();
    t_own_crc_bad();
    t_none();
    t_ones();
    t_start_clear();
    t_noisy();
    t_hold();
    rst_n = 0;
    @(negedge clk);
    t_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule